// File: doc/BRIEF.md
# Edge-Triggered Watchdog Timer

This block watches a service line driven by a processor and raises an active-low flag when the processor stops servicing it. A change of level on the service line, in either direction, counts as service. The line is sampled through a two-flop synchronizer. Each edge that reaches the timer restarts a cycle counter. When the counter reaches the configured timeout with no edge, a latched flag drives the output low. The output then stays low until the next edge.

System reset holds the counter at zero and clears the latched flag, so no timeout can build up while the system is in reset. A supply-good input gates the output directly. When the supply is bad, the output is low at once. When the supply recovers, the output follows it at once, with no recovery interval. The block never resets anything itself. A system that wants a missed service to cause a reset routes the output back to its manual reset path outside this block.

Top module: `svc_watchdog`

## Requirements
- R1: With no edge on the service line, the output goes low exactly TIMEOUT_CYCLES clock edges after the timer was last cleared, and is still high one edge earlier.
- R2: A rising edge and a falling edge on the service line each clear the timer and the latched flag. The clear takes effect on the third rising clock edge after the line changes: two synchronizer stages, then one register stage.
- R3: While the system reset input is 1, the counter is held at zero and the latched flag is cleared. This holds even if reset comes after a timeout, and the output is high while the supply is good. Counting starts on the first clock edge after release.
- R4: Once the output has gone low after a timeout, it stays low for any number of cycles until an edge reaches the timer.
- R5: When the supply-good input is 0, the output is 0 in the same cycle, whether or not a timeout has occurred.
- R6: When the supply-good input returns to 1 and there is no pending timeout, the output is 1 in the same cycle, with no added delay.
- R7: A service line stuck at 1 times out in the same way as a line stuck at 0, so a floating line cannot disable the watchdog.
- R8: If an edge reaches the timer on the same clock edge on which the timeout would occur, the edge wins: the timer clears and the output stays high.
- R9: The counter saturates at TIMEOUT_CYCLES and never wraps. After a long stall, one edge re-arms a full timeout period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sysRst | input | 1 | System reset state, active high, asynchronous |
| supplyOk | input | 1 | Supply-good flag, 1 when the supply is above threshold |
| wdi | input | 1 | Service line from the processor, asynchronous |
| wdoN | output | 1 | Watchdog flag, active low |

## Verification
A level change on the service line reaches the timer on the third rising clock edge after it is driven. The timeout lands TIMEOUT_CYCLES edges after that, or TIMEOUT_CYCLES edges after reset release. The supply gating is combinational and appears in the same cycle. The bench drives inputs on falling clock edges and counts rising edges from that point. It samples the output on the falling edge just before and just after each due edge, so both the "not yet" and the "now" value are checked. Supply checks are sampled one time step after the input is driven. The edge-versus-timeout collision is placed by counting back three edges from the timeout edge.

// File: rtl/svc_wd_pkg.sv
package svc_wd_pkg;
  // Strobes from the control to the datapath, valid within one cycle.
  typedef struct packed {
    logic clear;   // restart the timer and drop the latched timeout
    logic count;   // advance the timer by one
    logic expire;  // set the latched timeout on this edge
  } wdStrobe_t;
endpackage

// File: rtl/svc_wd_datapath.sv
module svc_wd_datapath
  import svc_wd_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 320,
  parameter int SYNC_STAGES    = 2,
  localparam int CNT_W         = $clog2(TIMEOUT_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             sysRst,
  input  logic             wdi,
  input  wdStrobe_t        strobes,
  output logic             edgeSeen,
  output logic             atLimit,
  output logic             nearLimit,
  output logic [CNT_W-1:0] cnt,
  output logic             expired
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or posedge sysRst) begin
        if (sysRst) syncQ <= '0;
        else        syncQ <= wdi;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or posedge sysRst) begin
        if (sysRst) syncQ <= '0;
        else        syncQ <= {syncQ[SYNC_STAGES-2:0], wdi};
      end
    end
  endgenerate

  always_ff @(posedge clk or posedge sysRst) begin
    if (sysRst) prevQ <= 1'b0;
    else        prevQ <= syncQ[SYNC_STAGES-1];
  end

  assign edgeSeen  = syncQ[SYNC_STAGES-1] ^ prevQ;
  assign atLimit   = (cnt == CNT_W'(TIMEOUT_CYCLES));
  assign nearLimit = (cnt == CNT_W'(TIMEOUT_CYCLES - 1));

  always_ff @(posedge clk or posedge sysRst) begin
    if (sysRst)             cnt <= '0;
    else if (strobes.clear) cnt <= '0;
    else if (strobes.count) cnt <= cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or posedge sysRst) begin
    if (sysRst)              expired <= 1'b0;
    else if (strobes.clear)  expired <= 1'b0;
    else if (strobes.expire) expired <= 1'b1;
  end
endmodule

// File: rtl/svc_wd_ctrl.sv
module svc_wd_ctrl
  import svc_wd_pkg::*;
(
  input  logic      edgeSeen,
  input  logic      atLimit,
  input  logic      nearLimit,
  output wdStrobe_t strobes
);
  // An edge always wins over a timeout due on the same clock edge.
  always_comb begin
    strobes.clear  = edgeSeen;
    strobes.count  = !edgeSeen && !atLimit;
    strobes.expire = !edgeSeen && nearLimit;
  end
endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog
  import svc_wd_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 320,
  parameter int SYNC_STAGES    = 2,
  localparam int CNT_W         = $clog2(TIMEOUT_CYCLES + 1)
) (
  input  logic clk,
  input  logic sysRst,
  input  logic supplyOk,
  input  logic wdi,
  output logic wdoN
);
  wdStrobe_t        strobes;
  logic             edgeSeen;
  logic             atLimit;
  logic             nearLimit;
  logic [CNT_W-1:0] cnt;
  logic             expired;

  svc_wd_ctrl u_ctrl (
    .edgeSeen (edgeSeen),
    .atLimit  (atLimit),
    .nearLimit(nearLimit),
    .strobes  (strobes)
  );

  svc_wd_datapath #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
    .SYNC_STAGES   (SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .sysRst   (sysRst),
    .wdi      (wdi),
    .strobes  (strobes),
    .edgeSeen (edgeSeen),
    .atLimit  (atLimit),
    .nearLimit(nearLimit),
    .cnt      (cnt),
    .expired  (expired)
  );

  assign wdoN = supplyOk && !expired;
endmodule

// File: rtl/svc_watchdog_chk.sv
module svc_watchdog_chk #(
  parameter int TIMEOUT_CYCLES = 320,
  localparam int CNT_W         = $clog2(TIMEOUT_CYCLES + 1)
) (
  input logic             clk,
  input logic             sysRst,
  input logic             supplyOk,
  input logic             wdoN,
  input logic             edgeSeen,
  input logic [CNT_W-1:0] cnt,
  input logic             expired
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    sysRst |-> (cnt == '0 && !expired)); // R3

  AST_EXPIRE_AT_LIMIT: assert property (@(posedge clk) disable iff (sysRst)
    $rose(expired) |-> (cnt == CNT_W'(TIMEOUT_CYCLES))); // R1

  AST_EDGE_CLEARS: assert property (@(posedge clk) disable iff (sysRst)
    edgeSeen |=> (cnt == '0 && !expired)); // R2 R8

  AST_EXPIRE_HOLDS: assert property (@(posedge clk) disable iff (sysRst)
    (expired && !edgeSeen) |=> expired); // R4

  AST_SUPPLY_FORCES_LOW: assert property (@(posedge clk)
    !supplyOk |-> !wdoN); // R5

  AST_SUPPLY_RELEASE: assert property (@(posedge clk)
    (supplyOk && !expired) |-> wdoN); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (sysRst)
    cnt <= CNT_W'(TIMEOUT_CYCLES)); // R9
endmodule

bind svc_watchdog svc_watchdog_chk #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_chk (
  .clk     (clk),
  .sysRst  (sysRst),
  .supplyOk(supplyOk),
  .wdoN    (wdoN),
  .edgeSeen(edgeSeen),
  .cnt     (cnt),
  .expired (expired)
);

// File: tb/svc_watchdog_test.sv
`timescale 1ns/1ps
module svc_watchdog_test;
  localparam int T = 24;

  logic clk = 1'b0;
  logic sysRst = 1'b1;
  logic supplyOk = 1'b1;
  logic wdi = 1'b0;
  logic wdoN;
  int   nChecks = 0;
  int   nFails = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  svc_watchdog #(.TIMEOUT_CYCLES(T)) uut (
    .clk(clk), .sysRst(sysRst), .supplyOk(supplyOk), .wdi(wdi), .wdoN(wdoN)
  );

  task automatic check(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: wdoN=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Leaves the bench on the falling edge where reset is released.
  task automatic doReset();
    @(negedge clk);
    sysRst = 1'b1; wdi = 1'b0; supplyOk = 1'b1;
    waitCycles(3);
    sysRst = 1'b0;
  endtask

  task automatic tStuckLow();
    doReset();
    waitCycles(T - 1); check("R1 one edge before timeout", wdoN, 1'b1);
    waitCycles(1);     check("R1 at timeout", wdoN, 1'b0);
  endtask

  task automatic tStuckHighAndEdges();
    doReset();
    wdi = 1'b1;                          // rising edge
    waitCycles(T + 2); check("R2 rise restarts timer", wdoN, 1'b1);
    waitCycles(1);     check("R7 line stuck high times out", wdoN, 0);
    waitCycles(50);    check("R4 stays low while line is still", wdoN, 0);
    wdi = 1'b0;                          // falling edge
    waitCycles(2);     check("R2 fall not yet through synchronizer", wdoN, 0);
    waitCycles(1);     check("R2 fall clears flag", wdoN, 1'b1);
  endtask

  task automatic tEdgeWins();
    doReset();
    waitCycles(T - 3);
    wdi = ~wdi;
    waitCycles(3);     check("R8 edge beats coincident timeout", wdoN, 1'b1);
    waitCycles(T - 1); check("R8 full period after collision", wdoN, 1'b1);
    waitCycles(1);     check("R8 timeout after collision", wdoN, 1'b0);
  endtask

  task automatic tSaturate();
    doReset();
    waitCycles(3 * T); check("R9 long stall stays low", wdoN, 1'b0);
    wdi = ~wdi;
    waitCycles(3);     check("R9 edge clears after stall", wdoN, 1'b1);
    waitCycles(T - 1); check("R9 full period re-armed", wdoN, 1'b1);
    waitCycles(1);     check("R9 timeout after re-arm", wdoN, 1'b0);
  endtask

  task automatic tSupply();
    doReset();
    waitCycles(5);
    supplyOk = 1'b0; #1; check("R5 supply low forces output low", wdoN, 1'b0);
    @(negedge clk);
    supplyOk = 1'b1; #1; check("R6 supply recovery releases at once", wdoN, 1'b1);
    waitCycles(T);       check("R5 timeout still low", wdoN, 1'b0);
    supplyOk = 1'b0; #1; check("R5 supply low while timed out", wdoN, 1'b0);
    @(negedge clk); supplyOk = 1'b1;
  endtask

  task automatic tResetHold();
    @(negedge clk);
    sysRst = 1'b1; wdi = 1'b0;
    waitCycles(3 * T); check("R3 no timeout during reset", wdoN, 1'b1);
    sysRst = 1'b0;
    waitCycles(T - 1); check("R3 counting starts at release", wdoN, 1'b1);
    waitCycles(1);     check("R3 timeout after release", wdoN, 1'b0);
    sysRst = 1'b1; #1; check("R3 reset clears latched timeout", wdoN, 1'b1);
    @(negedge clk); sysRst = 1'b0;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    waitCycles(2);
    check("R3 output high in reset", wdoN, 1'b1);
    tStuckLow();
    tStuckHighAndEdges();
    tEdgeWins();
    tSaturate();
    tSupply();
    tResetHold();
    done = 1'b1;
    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      finishRun();
    end
  end
endmodule